// File: doc/BRIEF.md
# Next-PC Branch and Jump Unit

This block holds the program counter of a fixed-width 32-bit instruction stream and works out where the next fetch goes. Each cycle it receives a flow code, a 16-bit branch displacement, a 26-bit jump index, a full target address read from a register, and a register value that an earlier compare left behind. It presents the chosen next PC and a taken flag combinationally, in the same cycle. When the advance enable is high, it loads that next PC on the clock edge.

There are five named flow kinds: SEQ, BEQZ, BNEZ, JUMP and JREG. SEQ steps past the current word. BEQZ and BNEZ test the condition register for zero or non-zero. A taken branch lands at the word after the current one, offset by the sign-extended displacement counted in words. JUMP keeps the top bits of the current PC and replaces the rest with the index field and two zero bits, so a direct jump stays inside its 256 MB region. JREG moves to the register-held address. If that address is not word aligned, the unit raises a warning flag.

Top module: `npc_unit`

## Requirements
- R1: While rst_ni is low, and after its release until the first enabled edge, pc_o equals the parameter RESET_VEC (default 32'h0000_0100).
- R2: When adv_en_i is low, pc_o keeps its value across the clock edge, whatever the other inputs are.
- R3: Flow code 0 (SEQ), and the unused codes 5 to 7, give next_pc_o = pc_o + 4 with taken_o = 0.
- R4: Flow code 1 (BEQZ) is taken only when cond_val_i is zero. When taken, next_pc_o = pc_o + 4 + (sign-extended br_disp_i shifted left by 2). When not taken, next_pc_o = pc_o + 4 and taken_o = 0.
- R5: Flow code 2 (BNEZ) is taken only when cond_val_i is non-zero. It uses the same target as R4, and pc_o + 4 with taken_o = 0 otherwise.
- R6: A displacement with bit 15 set moves the target backwards. For example, 16'hFFFC gives pc_o + 4 - 16.
- R7: Flow code 3 (JUMP) gives next_pc_o = {pc_o[31:28], j_index_i, 2'b00} with taken_o = 1.
- R8: Flow code 4 (JREG) gives next_pc_o = reg_target_i with taken_o = 1.
- R9: tgt_misaligned_o is 1 exactly when the flow is JREG and reg_target_i[1:0] is non-zero. The PC still loads the unaligned target.
- R10: next_pc_o and taken_o follow the inputs in the same cycle. pc_o takes the value next_pc_o had at the enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adv_en_i | input | 1 | Load next PC on this edge |
| flow_i | input | 3 | Flow code: 0 SEQ, 1 BEQZ, 2 BNEZ, 3 JUMP, 4 JREG |
| br_disp_i | input | 16 | Signed word displacement for branches |
| j_index_i | input | 26 | Word index for direct jumps |
| reg_target_i | input | 32 | Register-held jump target |
| cond_val_i | input | 32 | Register value tested by branches |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Selected next program counter |
| taken_o | output | 1 | Control transfer chosen |
| tgt_misaligned_o | output | 1 | JREG target not word aligned |

## Verification
A register jump to an unaligned address raises the taken flag and the misalignment flag in the same cycle. The bench provokes this with a JREG whose target ends in binary 10. It checks that both flags are high together, and that the PC then holds the exact unaligned value and steps by 4 from there. A second overlap pairs a held enable with a jump request. In that case next_pc_o must show the jump target while pc_o stays put.

// File: rtl/npc_pkg.sv
package npc_pkg;
    typedef enum logic [2:0] {
        FLOW_SEQ  = 3'd0,
        FLOW_BEQZ = 3'd1,
        FLOW_BNEZ = 3'd2,
        FLOW_JUMP = 3'd3,
        FLOW_JREG = 3'd4
    } flow_e;
endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
    parameter int PC_W   = 32,
    parameter int DISP_W = 16,
    parameter int JIDX_W = 26
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [DISP_W-1:0] disp,
    input  logic [JIDX_W-1:0] jidx,
    output logic [PC_W-1:0]   seq_pc,
    output logic [PC_W-1:0]   br_pc,
    output logic [PC_W-1:0]   jmp_pc
);
    localparam int REGION_W = PC_W - JIDX_W - 2;
    localparam int EXT_W    = PC_W - DISP_W - 2;

    logic [PC_W-1:0] byte_off;

    always_comb begin
        seq_pc   = pc + PC_W'(4);
        byte_off = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
        br_pc    = seq_pc + byte_off;
        jmp_pc   = {pc[PC_W-1 -: REGION_W], jidx, 2'b00};
    end
endmodule

// File: rtl/npc_cond.sv
module npc_cond #(
    parameter int PC_W = 32
) (
    input  npc_pkg::flow_e  kind,
    input  logic [PC_W-1:0] cond_val,
    output logic            br_go
);
    import npc_pkg::*;

    logic is_zero;

    always_comb begin
        is_zero = (cond_val == '0);
        unique case (kind)
            FLOW_BEQZ: br_go = is_zero;
            FLOW_BNEZ: br_go = !is_zero;
            default:   br_go = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
    parameter int          PC_W      = 32,
    parameter int          DISP_W    = 16,
    parameter int          JIDX_W    = 26,
    parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              adv_en_i,
    input  logic [2:0]        flow_i,
    input  logic [DISP_W-1:0] br_disp_i,
    input  logic [JIDX_W-1:0] j_index_i,
    input  logic [PC_W-1:0]   reg_target_i,
    input  logic [PC_W-1:0]   cond_val_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              taken_o,
    output logic              tgt_misaligned_o
);
    import npc_pkg::*;

    localparam int REGION_W = PC_W - JIDX_W - 2;

    flow_e           kind;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] seq_pc, br_pc, jmp_pc;
    logic            br_go;

    assign kind = flow_e'(flow_i);

    npc_targets #(.PC_W(PC_W), .DISP_W(DISP_W), .JIDX_W(JIDX_W)) u_targets (
        .pc     (pc_q),
        .disp   (br_disp_i),
        .jidx   (j_index_i),
        .seq_pc (seq_pc),
        .br_pc  (br_pc),
        .jmp_pc (jmp_pc)
    );

    npc_cond #(.PC_W(PC_W)) u_cond (
        .kind     (kind),
        .cond_val (cond_val_i),
        .br_go    (br_go)
    );

    // Output selection
    always_comb begin
        next_pc_o        = seq_pc;
        taken_o          = 1'b0;
        tgt_misaligned_o = 1'b0;
        unique case (kind)
            FLOW_BEQZ, FLOW_BNEZ: begin
                taken_o   = br_go;
                next_pc_o = br_go ? br_pc : seq_pc;
            end
            FLOW_JUMP: begin
                taken_o   = 1'b1;
                next_pc_o = jmp_pc;
            end
            FLOW_JREG: begin
                taken_o          = 1'b1;
                next_pc_o        = reg_target_i;
                tgt_misaligned_o = (reg_target_i[1:0] != 2'b00);
            end
            default: begin
                taken_o   = 1'b0;
                next_pc_o = seq_pc;
            end
        endcase
    end

    // PC register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       pc_q <= PC_W'(RESET_VEC);
        else if (adv_en_i) pc_q <= next_pc_o;
    end

    assign pc_o = pc_q;

    AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_en_i |=> $stable(pc_o)); // R2
    AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_en_i && !taken_o) |=> pc_o == $past(pc_o) + PC_W'(4)); // R3
    AST_JUMP_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_en_i && flow_i == 3'd3) |=> pc_o[PC_W-1 -: REGION_W] == $past(pc_o[PC_W-1 -: REGION_W])); // R7
    AST_MISALIGN_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tgt_misaligned_o |-> (flow_i == 3'd4 && taken_o)); // R9
    AST_LOAD_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_en_i |=> pc_o == $past(next_pc_o)); // R10
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        adv_en_i = 1'b0;
    logic [2:0]  flow_i = 3'd0;
    logic [15:0] br_disp_i = '0;
    logic [25:0] j_index_i = '0;
    logic [31:0] reg_target_i = '0;
    logic [31:0] cond_val_i = '0;
    logic [31:0] pc_o, next_pc_o;
    logic        taken_o, tgt_misaligned_o;

    localparam logic [31:0] RV = 32'h0000_0100;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] mpc;
    logic [31:0] q_pc[$];
    string       q_tag[$];

    npc_unit #(.RESET_VEC(RV)) i_npc_unit (.*);

    always #10 clk_i = ~clk_i;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] f, input logic [15:0] d, input logic [25:0] j,
                        input logic [31:0] tgt, input logic [31:0] cv, input logic en,
                        input string tag);
        logic [31:0] seq, br, exp_n;
        logic        exp_t, exp_m;
        @(negedge clk_i);
        flow_i = f; br_disp_i = d; j_index_i = j; reg_target_i = tgt;
        cond_val_i = cv; adv_en_i = en;
        seq   = mpc + 32'd4;
        br    = seq + {{14{d[15]}}, d, 2'b00};
        exp_n = seq; exp_t = 1'b0; exp_m = 1'b0;
        case (f)
            3'd1: if (cv == 0) begin exp_n = br; exp_t = 1'b1; end
            3'd2: if (cv != 0) begin exp_n = br; exp_t = 1'b1; end
            3'd3: begin exp_n = {mpc[31:28], j, 2'b00}; exp_t = 1'b1; end
            3'd4: begin exp_n = tgt; exp_t = 1'b1; exp_m = (tgt[1:0] != 0); end
            default: ;
        endcase
        #2;
        check({tag, " next_pc"}, next_pc_o, exp_n);
        check({tag, " taken"}, {31'd0, taken_o}, {31'd0, exp_t});
        check({tag, " misaligned"}, {31'd0, tgt_misaligned_o}, {31'd0, exp_m});
        if (en) mpc = exp_n;
        q_pc.push_back(mpc);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare the registered PC after each edge
    initial begin
        forever begin
            @(posedge clk_i);
            #1;
            if (q_pc.size() > 0) begin
                logic [31:0] e;
                string       t;
                e = q_pc.pop_front();
                t = q_tag.pop_front();
                check({t, " pc"}, pc_o, e);
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk_i);
        #1 check("R1 reset pc", pc_o, RV);
        @(negedge clk_i) rst_ni = 1'b1;
        #2 check("R1 pc after release", pc_o, RV);
        mpc = RV;
        step(3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 1'b1, "R3 seq");
        step(3'd5, 16'h7, 26'h1, 32'h0, 32'h0, 1'b1, "R3 code5 seq");
        step(3'd7, 16'h7, 26'h1, 32'h0, 32'h0, 1'b1, "R3 code7 seq");
        step(3'd3, 16'h0, 26'h12345, 32'h0, 32'h0, 1'b0, "R2 hold R10 comb");
        step(3'd1, 16'h0010, 26'h0, 32'h0, 32'h0, 1'b1, "R4 beqz taken");
        step(3'd1, 16'h0010, 26'h0, 32'h0, 32'h5, 1'b1, "R4 beqz not taken");
        step(3'd2, 16'h0020, 26'h0, 32'h0, 32'h1, 1'b1, "R5 bnez taken");
        step(3'd2, 16'h0020, 26'h0, 32'h0, 32'h0, 1'b1, "R5 bnez not taken");
        step(3'd1, 16'hFFFC, 26'h0, 32'h0, 32'h0, 1'b1, "R6 backward");
        step(3'd4, 16'h0, 26'h0, 32'hA000_0040, 32'h0, 1'b1, "R8 jreg");
        step(3'd3, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h0, 1'b1, "R7 jump region");
        step(3'd3, 16'h0, 26'h0000123, 32'h0, 32'h0, 1'b1, "R7 jump low");
        step(3'd4, 16'h0, 26'h0, 32'h0000_2002, 32'h0, 1'b1, "R9 jreg misaligned");
        step(3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 1'b1, "R9 seq after misaligned");
        step(3'd4, 16'h0, 26'h0, 32'h0000_2001, 32'h0, 1'b0, "R9 misaligned held R2");
        step(3'd2, 16'h8000, 26'h0, 32'h0, 32'hFFFF_FFFF, 1'b1, "R6 min disp");
        step(3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 1'b1, "R10 final");
        repeat (2) @(posedge clk_i);
        #3;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule